// File: doc/BRIEF.md
# Card Host Status and Interrupt Flag Register

This block gathers the status conditions of a memory-card host controller into one 32-bit word that software reads over a simple register port. Its inputs come from the command path, the data path, the DMA engine and the SDIO logic. Events arrive as single-cycle pulses, and conditions arrive as levels. Each flag in the word has its own clearing policy.

- **Cleared by a status read.** Data-side and completion-signal flags stay set until the status word is read.
- **Cleared by a command write.** Response-error flags survive status reads. They clear only when the next command is written.
- **Live levels.** DMA and read-wait flags are not stored. They show the present state of their source.

An interrupt-enable register selects which flags drive the single interrupt output. It has separate set and clear write ports, so individual bits change without a read-modify-write.

Status word layout (bit positions are part of the software contract):

| Group | Bits | Flags |
|---|---|---|
| Cleared by status read | 0..5 | slot-A SDIO interrupt, slot-B SDIO interrupt, completion signal received, data CRC16 error, data timeout, completion-signal timeout |
| Cleared by command write | 8..12 | response index mismatch, response direction error, response CRC7 error, response end-bit error, response timeout |
| Live level | 16..20 | TX buffer empty, RX buffer full, transmit finished, receive finished, SDIO read-wait active |

All other bits read 0.

Word addresses:

| Address | Access | Function |
|---|---|---|
| 0 | read | status word |
| 1 | write | enable-set |
| 2 | write | enable-clear |
| 3 | read | enable register |
| 4 | write | command (any data) |

Top module: `hostStatusReg`

## Requirements
- R1: After reset, every stored flag in bits 0..12 reads 0, the enable register (address 3) reads 0 and `irqOut` is low.
- R2: A pulse on `rdClrEvt[k]` sets status bit k (k = 0..5), and the bit stays set across later cycles. A read of address 0 returns the bit still set, and from the next cycle the bit reads 0. Slot A (bit 0) and slot B (bit 1) are set only by their own inputs.
- R3: A pulse on `cmdClrEvt[k]` sets status bit 8+k (k = 0..4). Reading the status word leaves the bit set. A write to address 4 clears all of bits 8..12 from the next cycle.
- R4: Status bits 16..20 equal `liveLvl[4:0]` in the same cycle, are never latched, and are unaffected by reads or writes.
- R5: When a set pulse and its group's clearing access (status read for bits 0..5, command write for bits 8..12) occur in the same cycle, the bit is set afterwards.
- R6: A write to address 1 ORs the data into the enable register. A write to address 2 clears the enable bits where the data is 1. Only bits that exist in the status word can be enabled; the others read 0 at address 3.
- R7: `irqOut` is high exactly when some status bit and the matching enable bit are both 1.
- R8: Only a read strobe to address 0 clears bits 0..5. Reads of other addresses, and writes to address 0, leave every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regRdEn | input | 1 | Read strobe, one cycle per read |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regAddr | input | 3 | Word address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data in the strobe cycle, 0 when no read |
| rdClrEvt | input | 6 | Event pulses for flags cleared by status read |
| cmdClrEvt | input | 5 | Event pulses for flags cleared by command write |
| liveLvl | input | 5 | Level conditions shown live |
| irqOut | output | 1 | Combined masked interrupt |

## Verification
Two things collide in this block: a flag's set pulse and the access that clears that flag's group can occur in the same clock. The bench provokes this directly. It pulses a completion-signal event during a status read, and a response-error event during a command write. It then confirms at the ports that the returned word shows the pre-clear value and that the flag reads set afterwards. Random traffic with sparse event pulses repeats these collisions many times, and every result is judged against a bench model that applies the set-over-clear rule.

// File: rtl/hsrPkg.sv
package hsrPkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 3;
  localparam int RD_N     = 6;
  localparam int CMD_N    = 5;
  localparam int LIVE_N   = 5;
  localparam int RD_LSB   = 0;
  localparam int CMD_LSB  = 8;
  localparam int LIVE_LSB = 16;

  localparam logic [ADDR_W-1:0] ADR_STATUS  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_IEN_SET = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_IEN_CLR = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_IEN     = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CMD     = 3'd4;

  function automatic logic [DATA_W-1:0] buildMask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < RD_N; i++)   m[RD_LSB + i]   = 1'b1;
    for (int i = 0; i < CMD_N; i++)  m[CMD_LSB + i]  = 1'b1;
    for (int i = 0; i < LIVE_N; i++) m[LIVE_LSB + i] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] VALID_MASK = buildMask();

  typedef struct packed {
    logic rdClr;
    logic cmdClr;
    logic ienSet;
    logic ienClr;
    logic selStatus;
    logic selIen;
  } ctrlStrobes_t;
endpackage

// File: rtl/hsrStickyBank.sv
module hsrStickyBank #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] setPulse,
  input  logic             clrStb,
  output logic [WIDTH-1:0] flags
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            flags[i] <= 1'b0;
      else if (setPulse[i]) flags[i] <= 1'b1;  // set has priority over clear
      else if (clrStb)      flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/hsrCtrl.sv
module hsrCtrl
  import hsrPkg::*;
(
  input  logic              regRdEn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobes_t      strb
);
  always_comb begin
    strb           = '0;
    strb.selStatus = regRdEn && (regAddr == ADR_STATUS);
    strb.selIen    = regRdEn && (regAddr == ADR_IEN);
    strb.rdClr     = strb.selStatus;
    strb.cmdClr    = regWrEn && (regAddr == ADR_CMD);
    strb.ienSet    = regWrEn && (regAddr == ADR_IEN_SET);
    strb.ienClr    = regWrEn && (regAddr == ADR_IEN_CLR);
  end
endmodule

// File: rtl/hsrDatapath.sv
module hsrDatapath
  import hsrPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [RD_N-1:0]   rdClrEvt,
  input  logic [CMD_N-1:0]  cmdClrEvt,
  input  logic [LIVE_N-1:0] liveLvl,
  output logic [RD_N-1:0]   rdFlags,
  output logic [CMD_N-1:0]  cmdFlags,
  output logic [DATA_W-1:0] ienReg,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  logic [DATA_W-1:0] statusWord;

  hsrStickyBank #(.WIDTH(RD_N)) u_rdBank (
    .clk(clk), .rstN(rstN), .setPulse(rdClrEvt), .clrStb(strb.rdClr), .flags(rdFlags));

  hsrStickyBank #(.WIDTH(CMD_N)) u_cmdBank (
    .clk(clk), .rstN(rstN), .setPulse(cmdClrEvt), .clrStb(strb.cmdClr), .flags(cmdFlags));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ienReg <= '0;
    else if (strb.ienSet) ienReg <= ienReg | (wrData & VALID_MASK);
    else if (strb.ienClr) ienReg <= ienReg & ~wrData;
  end

  always_comb begin
    statusWord                       = '0;
    statusWord[RD_LSB +: RD_N]       = rdFlags;
    statusWord[CMD_LSB +: CMD_N]     = cmdFlags;
    statusWord[LIVE_LSB +: LIVE_N]   = liveLvl;
  end

  always_comb begin
    if (strb.selStatus)   rdData = statusWord;
    else if (strb.selIen) rdData = ienReg;
    else                  rdData = '0;
  end

  assign irqOut = |(statusWord & ienReg);
endmodule

// File: rtl/hostStatusReg.sv
module hostStatusReg
  import hsrPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regRdEn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [RD_N-1:0]   rdClrEvt,
  input  logic [CMD_N-1:0]  cmdClrEvt,
  input  logic [LIVE_N-1:0] liveLvl,
  output logic              irqOut
);
  ctrlStrobes_t      strb;
  logic [RD_N-1:0]   rdFlags;
  logic [CMD_N-1:0]  cmdFlags;
  logic [DATA_W-1:0] ienReg;

  hsrCtrl u_ctrl (
    .regRdEn(regRdEn), .regWrEn(regWrEn), .regAddr(regAddr), .strb(strb));

  hsrDatapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWrData),
    .rdClrEvt(rdClrEvt), .cmdClrEvt(cmdClrEvt), .liveLvl(liveLvl),
    .rdFlags(rdFlags), .cmdFlags(cmdFlags), .ienReg(ienReg),
    .rdData(regRdData), .irqOut(irqOut));
endmodule

// File: rtl/hsrChecker.sv
module hsrChecker
  import hsrPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regRdEn,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [RD_N-1:0]   rdClrEvt,
  input logic [CMD_N-1:0]  cmdClrEvt,
  input logic [RD_N-1:0]   rdFlags,
  input logic [CMD_N-1:0]  cmdFlags,
  input logic [DATA_W-1:0] ienReg,
  input logic              irqOut
);
  logic statusRd, cmdWr, ienSetWr;
  assign statusRd = regRdEn && (regAddr == ADR_STATUS);
  assign cmdWr    = regWrEn && (regAddr == ADR_CMD);
  assign ienSetWr = regWrEn && (regAddr == ADR_IEN_SET);

  p_rd_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    statusRd |=> ((rdFlags & ~$past(rdClrEvt)) == '0));

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !statusRd |=> (($past(rdFlags) & ~rdFlags) == '0));

  p_cmd_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !cmdWr |=> (($past(cmdFlags) & ~cmdFlags) == '0));

  p_cmd_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr |=> (cmdFlags == $past(cmdClrEvt)));

  p_rd_set_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdClrEvt != '0) |=> ((rdFlags & $past(rdClrEvt)) == $past(rdClrEvt)));

  p_cmd_set_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdClrEvt != '0) |=> ((cmdFlags & $past(cmdClrEvt)) == $past(cmdClrEvt)));

  p_ien_set_keeps_r6: assert property (@(posedge clk) disable iff (!rstN)
    ienSetWr |=> ((ienReg & $past(ienReg)) == $past(ienReg)));

  p_ien_legal_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((ienReg & ~VALID_MASK) == '0));

  p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ienReg == '0) |-> !irqOut);
endmodule

bind hostStatusReg hsrChecker chk (
  .clk(clk), .rstN(rstN), .regRdEn(regRdEn), .regWrEn(regWrEn), .regAddr(regAddr),
  .rdClrEvt(rdClrEvt), .cmdClrEvt(cmdClrEvt), .rdFlags(rdFlags), .cmdFlags(cmdFlags),
  .ienReg(ienReg), .irqOut(irqOut));

// File: tb/tb_hostStatusReg.sv
module tb_hostStatusReg;
  import hsrPkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regRdEn = 1'b0, regWrEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [DATA_W-1:0] regWrData = '0;
  logic [DATA_W-1:0] regRdData;
  logic [RD_N-1:0]   rdClrEvt = '0;
  logic [CMD_N-1:0]  cmdClrEvt = '0;
  logic [LIVE_N-1:0] liveLvl = '0;
  logic              irqOut;

  int checks = 0;
  int errors = 0;

  logic [RD_N-1:0]   mRd;
  logic [CMD_N-1:0]  mCmd;
  logic [DATA_W-1:0] mIen;

  always #5 clk = ~clk;

  hostStatusReg dut (
    .clk(clk), .rstN(rstN), .regRdEn(regRdEn), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .rdClrEvt(rdClrEvt),
    .cmdClrEvt(cmdClrEvt), .liveLvl(liveLvl), .irqOut(irqOut));

  function automatic logic [31:0] expWord(logic [5:0] r, logic [4:0] c, logic [4:0] l);
    logic [31:0] w;
    w = '0;
    w[5:0]   = r;
    w[12:8]  = c;
    w[20:16] = l;
    return w;
  endfunction

  function automatic logic [31:0] legalMask();
    return 32'h001F_1F3F;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    regRdEn = 0; regWrEn = 0; regAddr = '0; regWrData = '0;
    rdClrEvt = '0; cmdClrEvt = '0;
  endtask

  // Drive at negedge, check combinational outputs, advance, update model.
  task automatic step(input string req);
    #1;
    if (regRdEn && regAddr == ADR_STATUS)
      check(req, regRdData, expWord(mRd, mCmd, liveLvl));
    else if (regRdEn && regAddr == ADR_IEN)
      check(req, regRdData, mIen);
    check("R7 irq", {31'b0, irqOut},
          {31'b0, |(expWord(mRd, mCmd, liveLvl) & mIen)});
    @(posedge clk);
    mRd  = ((regRdEn && regAddr == ADR_STATUS) ? '0 : mRd) | rdClrEvt;
    mCmd = ((regWrEn && regAddr == ADR_CMD) ? '0 : mCmd) | cmdClrEvt;
    if (regWrEn && regAddr == ADR_IEN_SET) mIen = mIen | (regWrData & legalMask());
    else if (regWrEn && regAddr == ADR_IEN_CLR) mIen = mIen & ~regWrData;
    @(negedge clk);
    idle();
  endtask

  task automatic rdStatus(input string req);
    regRdEn = 1; regAddr = ADR_STATUS; step(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    mRd = '0; mCmd = '0; mIen = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    regRdEn = 1; regAddr = ADR_STATUS; #1;
    check("R1 status", regRdData, 32'h0);
    regAddr = ADR_IEN; #1;
    check("R1 enable", regRdData, 32'h0);
    check("R1 irq", {31'b0, irqOut}, 32'h0);
    idle();

    // R2 sticky until read, slots independent
    rdClrEvt = 6'b000001; step("R2");
    step("R2");
    rdStatus("R2 slotA only");
    rdStatus("R2 cleared");
    rdClrEvt = 6'b000010; step("R2");
    rdStatus("R2 slotB only");

    // R3 survives status read, cleared by command write
    cmdClrEvt = 5'b10100; step("R3");
    rdStatus("R3 survives read");
    rdStatus("R3 still set");
    regWrEn = 1; regAddr = ADR_CMD; regWrData = 32'hDEAD_BEEF; step("R3");
    rdStatus("R3 cleared by cmd");

    // R4 live levels
    liveLvl = 5'b10110; rdStatus("R4 live");
    liveLvl = 5'b00001; rdStatus("R4 follows");
    liveLvl = 5'b00000; rdStatus("R4 not latched");

    // R5 collisions
    rdClrEvt = 6'b000100; step("R5");
    regRdEn = 1; regAddr = ADR_STATUS; rdClrEvt = 6'b001000; step("R5 read shows old");
    rdStatus("R5 set wins read");
    cmdClrEvt = 5'b00001; step("R5");
    regWrEn = 1; regAddr = ADR_CMD; cmdClrEvt = 5'b00010; step("R5");
    rdStatus("R5 set wins cmd");
    regWrEn = 1; regAddr = ADR_CMD; step("R5");

    // R8 other accesses do not clear
    rdClrEvt = 6'b100000; step("R8");
    regRdEn = 1; regAddr = ADR_IEN; step("R8 ien read");
    regWrEn = 1; regAddr = ADR_STATUS; regWrData = 32'hFFFF_FFFF; step("R8");
    regRdEn = 1; regAddr = ADR_CMD; step("R8");
    rdStatus("R8 still set");
    rdStatus("R8 cleared");

    // R6 enable set/clear, illegal bits dropped
    regWrEn = 1; regAddr = ADR_IEN_SET; regWrData = 32'hFFFF_FFFF; step("R6");
    regRdEn = 1; regAddr = ADR_IEN; step("R6 legal bits");
    regWrEn = 1; regAddr = ADR_IEN_CLR; regWrData = 32'h0000_FF0F; step("R6");
    regRdEn = 1; regAddr = ADR_IEN; step("R6 after clear");

    // R7 enabled flag raises irq
    rdClrEvt = 6'b010000; step("R7");
    step("R7 irq on");
    rdStatus("R7");
    step("R7 irq off");

    // Random traffic (R2 R3 R4 R5 R6 R7 R8)
    for (int i = 0; i < 3000; i++) begin
      int sel;
      sel = $urandom_range(0, 9);
      for (int b = 0; b < RD_N; b++)  rdClrEvt[b]  = ($urandom_range(0, 15) == 0);
      for (int b = 0; b < CMD_N; b++) cmdClrEvt[b] = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 7) == 0) liveLvl = 5'($urandom);
      case (sel)
        0, 1, 2: begin regRdEn = 1; regAddr = ADR_STATUS; end
        3:       begin regRdEn = 1; regAddr = ADR_IEN; end
        4:       begin regWrEn = 1; regAddr = ADR_CMD; regWrData = $urandom; end
        5:       begin regWrEn = 1; regAddr = ADR_IEN_SET; regWrData = $urandom; end
        6:       begin regWrEn = 1; regAddr = ADR_IEN_CLR; regWrData = $urandom; end
        7:       begin regRdEn = 1; regAddr = 3'($urandom); end
        default: ;
      endcase
      step("R2/R3/R4/R5/R6/R8 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule